// File: doc/BRIEF.md
# Decode-Stage Stall and Flush Controller

This block decides, once per cycle, whether a five-stage pipeline must freeze its front end. It looks at the two source register numbers of the instruction sitting in decode and at the instructions one and two stages ahead of it, including whether each writes a register, whether it is a load, and which register it targets. From these it raises a hold for the program counter, a hold for the fetch/decode register and a bubble that empties the control fields of the execute stage. Branches in this pipeline compare their operands in decode. Such a branch therefore has to wait for producers that forwarding cannot yet reach. The wait is one cycle or two, depending on whether the producer is an ALU operation or a load and how far ahead it is.

The stall depth is fixed when the hazard is first seen. A small down-counter then keeps the stall up for the rest of that depth, so the second cycle of a load-to-branch wait does not depend on how the stage registers evolve. When a branch in decode is resolved taken and no stall is active, the block flushes the one instruction fetched behind it. The stage registers and the forwarding network sit outside this block.

Top module: `hzd_stall_ctrl`

## Requirements
- R1: When the execute-stage instruction is a load whose destination (nonzero) equals the decode rs or rt, and decode holds no branch, the bubble and both holds are high for exactly that one cycle.
- R2: Whenever a stall is active, pc_hold, ifid_hold and idex_bubble are all high together; otherwise all three are low.
- R3: A decode branch whose rs or rt equals the nonzero destination of a register-writing, non-load instruction in execute stalls for one cycle.
- R4: A decode branch whose rs or rt equals the nonzero destination of a load in the memory stage stalls for one cycle.
- R5: A decode branch whose rs or rt equals the nonzero destination of a load in execute stalls for two consecutive cycles. The second cycle is held by the internal count even if the inputs then show no hazard.
- R6: A producer whose destination is register 0 never causes a stall.
- R7: A branch in decode that is marked taken while no stall is active raises ifid_flush in that same cycle.
- R8: Stall wins over flush: ifid_flush is never high in a cycle with idex_bubble high.
- R9: After reset, with no producer active, all four outputs are low.
- R10: An ALU producer in execute never stalls a non-branch instruction in decode. A producer in execute with neither its write flag nor its load flag set never stalls anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_rs | input | REG_W | First source register of the decode instruction |
| dec_rt | input | REG_W | Second source register of the decode instruction |
| dec_is_branch | input | 1 | Decode instruction is a register-compare branch |
| dec_br_taken | input | 1 | Decode comparator result: branch taken |
| ex_mem_read | input | 1 | Execute-stage instruction is a load |
| ex_reg_write | input | 1 | Execute-stage instruction writes a register |
| ex_dst | input | REG_W | Destination register of the execute-stage instruction |
| mem_mem_read | input | 1 | Memory-stage instruction is a load |
| mem_dst | input | REG_W | Destination register of the memory-stage instruction |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble | output | 1 | Zero the control fields entering execute |
| ifid_flush | output | 1 | Zero the fetch/decode register (taken branch) |

## Verification
The holds, the bubble and the flush are combinational from the stage inputs, so the first stall cycle and any flush are due in the cycle the inputs are applied. Only the second cycle of a load-to-branch wait comes from the registered count, one clock edge later. The driver applies each stage snapshot on the falling edge and queues the expected outputs for that cycle. The monitor compares them 2 ns later, well before the next rising edge. Each multi-cycle sequence is applied as consecutive snapshots, so a stall that lasts one cycle too long or one cycle too short shows up as a mismatch on a specific queued entry.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    // Match result of one producer against the two decode sources
    typedef struct packed {
        logic rs;
        logic rt;
    } src_hit_t;

endpackage

// File: rtl/hzd_src_match.sv
module hzd_src_match
    import hzd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             wr_en,
    input  logic [REG_W-1:0] dst,
    input  logic [REG_W-1:0] src_rs,
    input  logic [REG_W-1:0] src_rt,
    output src_hit_t         hit
);

    logic live;

    // Register 0 is hardwired and never carries a dependency
    assign live   = wr_en && (dst != '0);
    assign hit.rs = live && (dst == src_rs);
    assign hit.rt = live && (dst == src_rt);

endmodule

// File: rtl/hzd_stall_seq.sv
module hzd_stall_seq #(
    parameter int SHORT_CYCLES = 1,
    parameter int LONG_CYCLES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_short,
    input  logic start_long,
    output logic stall
);

    localparam int CW = (LONG_CYCLES > 1) ? $clog2(LONG_CYCLES) + 1 : 1;
    localparam logic [CW-1:0] SHORT_LEFT = CW'(SHORT_CYCLES - 1);
    localparam logic [CW-1:0] LONG_LEFT  = CW'(LONG_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] left;
    } seq_t;

    seq_t q, d;
    logic [CW-1:0] carry_on;
    logic [CW-1:0] fresh;

    always_comb begin
        d        = q;
        carry_on = (q.left != '0) ? q.left - 1'b1 : '0;
        if (start_long)
            fresh = LONG_LEFT;
        else if (start_short)
            fresh = SHORT_LEFT;
        else
            fresh = '0;
        // Keep the longer of the pending and the newly requested wait
        d.left = (fresh > carry_on) ? fresh : carry_on;
        stall  = (q.left != '0) || start_short || start_long;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

endmodule

// File: rtl/hzd_stall_ctrl.sv
module hzd_stall_ctrl
    import hzd_pkg::*;
#(
    parameter int REG_W        = 5,
    parameter int SHORT_CYCLES = 1,
    parameter int LONG_CYCLES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] dec_rs,
    input  logic [REG_W-1:0] dec_rt,
    input  logic             dec_is_branch,
    input  logic             dec_br_taken,
    input  logic             ex_mem_read,
    input  logic             ex_reg_write,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             mem_mem_read,
    input  logic [REG_W-1:0] mem_dst,
    output logic             pc_hold,
    output logic             ifid_hold,
    output logic             idex_bubble,
    output logic             ifid_flush
);

    src_hit_t ex_hit;
    src_hit_t mem_hit;
    logic     ex_dep;
    logic     mem_dep;
    logic     start_short;
    logic     start_long;
    logic     stall;

    hzd_src_match #(.REG_W(REG_W)) ex_match_i (
        .wr_en  (ex_reg_write || ex_mem_read),
        .dst    (ex_dst),
        .src_rs (dec_rs),
        .src_rt (dec_rt),
        .hit    (ex_hit)
    );

    // Only a load two stages ahead is out of reach for a decode compare
    hzd_src_match #(.REG_W(REG_W)) mem_match_i (
        .wr_en  (mem_mem_read),
        .dst    (mem_dst),
        .src_rs (dec_rs),
        .src_rt (dec_rt),
        .hit    (mem_hit)
    );

    always_comb begin
        ex_dep      = ex_hit.rs || ex_hit.rt;
        mem_dep     = mem_hit.rs || mem_hit.rt;
        start_long  = dec_is_branch && ex_mem_read && ex_dep;
        start_short = (!dec_is_branch && ex_mem_read && ex_dep)
                   || (dec_is_branch && !ex_mem_read && ex_dep)
                   || (dec_is_branch && mem_dep);
    end

    hzd_stall_seq #(
        .SHORT_CYCLES (SHORT_CYCLES),
        .LONG_CYCLES  (LONG_CYCLES)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_short (start_short),
        .start_long  (start_long),
        .stall       (stall)
    );

    assign pc_hold     = stall;
    assign ifid_hold   = stall;
    assign idex_bubble = stall;
    assign ifid_flush  = dec_is_branch && dec_br_taken && !stall;

endmodule

// File: rtl/hzd_stall_ctrl_chk.sv
module hzd_stall_ctrl_chk #(
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] dec_rs,
    input logic [REG_W-1:0] dec_rt,
    input logic             dec_is_branch,
    input logic             dec_br_taken,
    input logic             ex_mem_read,
    input logic             ex_reg_write,
    input logic [REG_W-1:0] ex_dst,
    input logic             mem_mem_read,
    input logic [REG_W-1:0] mem_dst,
    input logic             pc_hold,
    input logic             ifid_hold,
    input logic             idex_bubble,
    input logic             ifid_flush
);

    logic ex_load_dep;
    assign ex_load_dep = ex_mem_read && (ex_dst != '0)
                      && ((ex_dst == dec_rs) || (ex_dst == dec_rt));

    assert_load_use_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ex_load_dep |-> idex_bubble);

    assert_load_branch_second_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_load_dep && dec_is_branch) |=> idex_bubble);

    assert_zero_dst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((ex_dst == '0) && (mem_dst == '0) && !$past(idex_bubble)) |-> !idex_bubble);

    assert_taken_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_is_branch && dec_br_taken && !pc_hold) |-> ifid_flush);

    assert_stall_over_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        idex_bubble |-> !ifid_flush);

endmodule

bind hzd_stall_ctrl hzd_stall_ctrl_chk #(.REG_W(REG_W)) chk_i (.*);

// File: tb/hzd_stall_ctrl_tb_top.sv
`timescale 1ns/1ps
module hzd_stall_ctrl_tb_top;

    localparam int REG_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [REG_W-1:0] dec_rs = '0;
    logic [REG_W-1:0] dec_rt = '0;
    logic             dec_is_branch = 1'b0;
    logic             dec_br_taken = 1'b0;
    logic             ex_mem_read = 1'b0;
    logic             ex_reg_write = 1'b0;
    logic [REG_W-1:0] ex_dst = '0;
    logic             mem_mem_read = 1'b0;
    logic [REG_W-1:0] mem_dst = '0;
    logic             pc_hold;
    logic             ifid_hold;
    logic             idex_bubble;
    logic             ifid_flush;

    typedef struct {
        logic  bubble;
        logic  flush;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 1'b0;

    always #4 clk = ~clk;

    hzd_stall_ctrl dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .dec_rs        (dec_rs),
        .dec_rt        (dec_rt),
        .dec_is_branch (dec_is_branch),
        .dec_br_taken  (dec_br_taken),
        .ex_mem_read   (ex_mem_read),
        .ex_reg_write  (ex_reg_write),
        .ex_dst        (ex_dst),
        .mem_mem_read  (mem_mem_read),
        .mem_dst       (mem_dst),
        .pc_hold       (pc_hold),
        .ifid_hold     (ifid_hold),
        .idex_bubble   (idex_bubble),
        .ifid_flush    (ifid_flush)
    );

    // Driver: one stage snapshot per cycle, expectation queued for the monitor
    task automatic step(input logic br, input logic tk,
                        input logic [REG_W-1:0] rs, input logic [REG_W-1:0] rt,
                        input logic exr, input logic exw, input logic [REG_W-1:0] exd,
                        input logic mr, input logic [REG_W-1:0] md,
                        input logic eb, input logic ef, input string tag);
        exp_t e;
        @(negedge clk);
        dec_is_branch = br;
        dec_br_taken  = tk;
        dec_rs        = rs;
        dec_rt        = rt;
        ex_mem_read   = exr;
        ex_reg_write  = exw;
        ex_dst        = exd;
        mem_mem_read  = mr;
        mem_dst       = md;
        e.bubble = eb;
        e.flush  = ef;
        e.tag    = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compares 2 ns after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() != 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_chk++;
                if (idex_bubble !== e.bubble || pc_hold !== e.bubble || ifid_hold !== e.bubble) begin
                    n_err++;
                    $display("FAIL %s: bubble/pc_hold/ifid_hold = %b/%b/%b expected %b",
                             e.tag, idex_bubble, pc_hold, ifid_hold, e.bubble);
                end
                n_chk++;
                if (ifid_flush !== e.flush) begin
                    n_err++;
                    $display("FAIL %s: ifid_flush = %b expected %b", e.tag, ifid_flush, e.flush);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: idle after reset
        step(0,0, 5'd0,5'd0, 0,0,5'd0, 0,5'd0, 0,0, "R9 reset idle");

        // R1: load-use on rs, then on rt; one cycle each
        step(0,0, 5'd3,5'd9, 1,1,5'd3, 0,5'd0, 1,0, "R1 load-use rs");
        step(0,0, 5'd3,5'd9, 0,0,5'd0, 1,5'd3, 0,0, "R1 load-use released");
        step(0,0, 5'd8,5'd3, 1,1,5'd3, 0,5'd0, 1,0, "R1 load-use rt");
        step(0,0, 5'd8,5'd3, 0,0,5'd0, 1,5'd3, 0,0, "R1 rt released");

        // R10: ALU producer before non-branch; no-write producer before branch
        step(0,0, 5'd4,5'd4, 0,1,5'd4, 0,5'd0, 0,0, "R10 alu to non-branch");
        step(1,0, 5'd5,5'd1, 0,0,5'd5, 0,5'd0, 0,0, "R10 no-write producer");

        // R3 + R8 + R7: ALU then taken branch
        step(1,1, 5'd5,5'd2, 0,1,5'd5, 0,5'd0, 1,0, "R3 R8 alu-branch stall");
        step(1,1, 5'd5,5'd2, 0,0,5'd0, 0,5'd0, 0,1, "R7 flush after stall");

        // R4: load two ahead of a not-taken branch
        step(1,0, 5'd1,5'd4, 0,1,5'd7, 1,5'd4, 1,0, "R4 mem-load branch");
        step(1,0, 5'd1,5'd4, 0,0,5'd0, 0,5'd0, 0,0, "R4 released");

        // R5: load right ahead of a taken branch, realistic stage flow
        step(1,1, 5'd6,5'd2, 1,1,5'd6, 0,5'd0, 1,0, "R5 load-branch cycle1");
        step(1,1, 5'd6,5'd2, 0,0,5'd0, 1,5'd6, 1,0, "R5 load-branch cycle2");
        step(1,1, 5'd6,5'd2, 0,0,5'd0, 0,5'd0, 0,1, "R5 then flush");

        // R5: second cycle held by the count alone
        step(1,0, 5'd2,5'd6, 1,1,5'd6, 0,5'd0, 1,0, "R5 count cycle1");
        step(1,1, 5'd2,5'd6, 0,0,5'd0, 0,5'd0, 1,0, "R5 count cycle2 R8");
        step(1,1, 5'd2,5'd6, 0,0,5'd0, 0,5'd0, 0,1, "R5 count done");

        // R6: register 0 never stalls
        step(0,0, 5'd0,5'd0, 1,1,5'd0, 0,5'd0, 0,0, "R6 load dst zero");
        step(1,1, 5'd0,5'd0, 1,1,5'd0, 1,5'd0, 0,1, "R6 branch dst zero");

        // R2: back to idle
        step(0,0, 5'd1,5'd2, 0,0,5'd0, 0,5'd0, 0,0, "R2 idle holds low");

        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

endmodule